// File: doc/BRIEF.md
# Cross Trigger Routing Unit

This block distributes debug events between agents on a chip. A set of trigger inputs feeds a small group of broadcast channels, and those channels in turn drive a set of trigger outputs. Software chooses the routing for each trigger with a channel mask. An input mask selects which channels that input raises. An output mask selects which channels that output responds to. Software can also raise channels by itself, either as a steady level or as a single-cycle pulse.

Each trigger output is a sticky level, so it can serve directly as an interrupt request. It stays high until software acknowledges it. All configuration goes through a simple 32-bit register port with a word address, a write strobe and a combinational read path. Writes are refused until a fixed 32-bit key has been written to the lock register. A control bit gates the whole unit.

The bus address is a word index, which is the byte offset divided by four. The defaults are 8 inputs, 8 outputs and 4 channels.

Top module: `cross_trig_router`

## Requirements
- R1: After reset the unit is locked (word 0x3ED bit 0 reads 1), disabled (word 0x000 reads 0), every mask is zero and every trigger output is low.
- R2: The input-n mask lives at word 0x008+n and the output-m mask at word 0x028+m. Only the low 4 bits are stored, and they read back. Bit c of a mask links that trigger to channel c.
- R3: Writing 0xC5ACCE55 to word 0x3EC unlocks the unit, and writing any other value there locks it. Word 0x3ED bit 0 reads 1 while locked and 0 while unlocked.
- R4: While the unit is locked, a write to any word other than 0x3EC changes no state.
- R5: Word 0x000 bit 0 is the unit enable. While it is 0, every trigger output is driven low, starting from the cycle after the disable write took effect.
- R6: A channel is active when a high input whose mask holds that channel drives it, or when its application-level or pulse bit is set. While the unit is enabled, output m goes high on the clock edge after any channel in its mask is active, and it stays high afterwards.
- R7: Writing a 1 to bit m of word 0x004 clears output m on that edge. If a channel in output m's mask is active in that same cycle, the output stays high instead.
- R8: Writing word 0x005 ORs the written bits into the persistent application channels. Writing word 0x006 clears the written bits. Reading word 0x005 returns the current application channels.
- R9: Writing word 0x007 makes the written channel bits active for exactly the one cycle after the write.
- R10: Reads return live status. Word 0x04C gives the input levels and word 0x04D the output levels. Word 0x04E gives the channel activity before enable gating, and word 0x04F gives it after enable gating.
- R11: Reads of unmapped words return zero. So do reads of the write-only words 0x004, 0x006, 0x007 and 0x3EC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| trig_in | input | 8 | Trigger input levels |
| trig_out | output | 8 | Latched trigger outputs |

## Verification
The assertions check four rules on every cycle. The lock must hold all configuration steady against refused writes. The key register must set the lock state on the edge after each write. The outputs must stay low while the unit is disabled and must not drop without an acknowledge. An acknowledge with no active channel must clear its output, and a pulse must last no longer than one cycle. Only the bench scenarios show that the routing is correct end to end. Those scenarios cover an input reaching the right output through the right channel, set winning over acknowledge, the application and pulse sources, masks truncated to the channel count, and the status and unmapped read values.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int DEF_NUM_IN  = 8;
    localparam int DEF_NUM_OUT = 8;
    localparam int DEF_NUM_CH  = 4;
    localparam int ADDR_W      = 10;
    localparam int DATA_W      = 32;

    // word addresses (byte offset / 4)
    localparam logic [ADDR_W-1:0] A_CTRL      = 10'h000;
    localparam logic [ADDR_W-1:0] A_ACK       = 10'h004;
    localparam logic [ADDR_W-1:0] A_APP_SET   = 10'h005;
    localparam logic [ADDR_W-1:0] A_APP_CLR   = 10'h006;
    localparam logic [ADDR_W-1:0] A_APP_PULSE = 10'h007;
    localparam logic [ADDR_W-1:0] A_IN_BASE   = 10'h008;
    localparam logic [ADDR_W-1:0] A_OUT_BASE  = 10'h028;
    localparam logic [ADDR_W-1:0] A_ST_IN     = 10'h04C;
    localparam logic [ADDR_W-1:0] A_ST_OUT    = 10'h04D;
    localparam logic [ADDR_W-1:0] A_ST_CHIN   = 10'h04E;
    localparam logic [ADDR_W-1:0] A_ST_CHOUT  = 10'h04F;
    localparam logic [ADDR_W-1:0] A_KEY       = 10'h3EC;
    localparam logic [ADDR_W-1:0] A_KEYSTAT   = 10'h3ED;

    localparam logic [DATA_W-1:0] UNLOCK_KEY  = 32'hC5AC_CE55;

    typedef enum logic {UNLOCKED = 1'b0, LOCKED = 1'b1} lock_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [ADDR_W-1:0] slot_addr(logic [ADDR_W-1:0] base, int idx);
        return base + ADDR_W'(idx);
    endfunction

endpackage

// File: rtl/ctr_regs.sv
module ctr_regs
    import ctr_pkg::*;
#(
    parameter int NUM_IN  = DEF_NUM_IN,
    parameter int NUM_OUT = DEF_NUM_OUT,
    parameter int NUM_CH  = DEF_NUM_CH
) (
    input  logic                            clk,
    input  logic                            rst,
    input  bus_req_t                        req,
    input  logic [NUM_IN-1:0]               trig_in,
    input  logic [NUM_OUT-1:0]              trig_out,
    input  logic [NUM_CH-1:0]               chan_in,
    input  logic [NUM_CH-1:0]               chan_out,
    output logic                            en,
    output logic [NUM_CH-1:0]               app_ch,
    output logic [NUM_CH-1:0]               pulse_ch,
    output logic [NUM_IN-1:0][NUM_CH-1:0]   in_mask,
    output logic [NUM_OUT-1:0][NUM_CH-1:0]  out_mask,
    output logic [NUM_OUT-1:0]              ack,
    output logic [DATA_W-1:0]               rdata
);

    lock_e                          lock_q;
    logic                           en_q;
    logic [NUM_CH-1:0]              app_q;
    logic [NUM_CH-1:0]              pulse_q;
    logic [NUM_IN-1:0][NUM_CH-1:0]  in_mask_q;
    logic [NUM_OUT-1:0][NUM_CH-1:0] out_mask_q;
    logic                           wr_ok;

    assign wr_ok = req.we && (lock_q == UNLOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q     <= LOCKED;
            en_q       <= 1'b0;
            app_q      <= '0;
            pulse_q    <= '0;
            in_mask_q  <= '0;
            out_mask_q <= '0;
        end else begin
            pulse_q <= '0;
            if (req.we && req.addr == A_KEY)
                lock_q <= (req.wdata == UNLOCK_KEY) ? UNLOCKED : LOCKED;
            if (wr_ok) begin
                if (req.addr == A_CTRL)      en_q    <= req.wdata[0];
                if (req.addr == A_APP_SET)   app_q   <= app_q | req.wdata[NUM_CH-1:0];
                if (req.addr == A_APP_CLR)   app_q   <= app_q & ~req.wdata[NUM_CH-1:0];
                if (req.addr == A_APP_PULSE) pulse_q <= req.wdata[NUM_CH-1:0];
                for (int n = 0; n < NUM_IN; n++)
                    if (req.addr == slot_addr(A_IN_BASE, n))
                        in_mask_q[n] <= req.wdata[NUM_CH-1:0];
                for (int m = 0; m < NUM_OUT; m++)
                    if (req.addr == slot_addr(A_OUT_BASE, m))
                        out_mask_q[m] <= req.wdata[NUM_CH-1:0];
            end
        end
    end

    assign ack      = (wr_ok && req.addr == A_ACK) ? req.wdata[NUM_OUT-1:0] : '0;
    assign en       = en_q;
    assign app_ch   = app_q;
    assign pulse_ch = pulse_q;
    assign in_mask  = in_mask_q;
    assign out_mask = out_mask_q;

    always_comb begin
        rdata = '0;
        case (req.addr)
            A_CTRL:     rdata[0]          = en_q;
            A_APP_SET:  rdata[NUM_CH-1:0] = app_q;
            A_ST_IN:    rdata[NUM_IN-1:0] = trig_in;
            A_ST_OUT:   rdata[NUM_OUT-1:0]= trig_out;
            A_ST_CHIN:  rdata[NUM_CH-1:0] = chan_in;
            A_ST_CHOUT: rdata[NUM_CH-1:0] = chan_out;
            A_KEYSTAT:  rdata[0]          = (lock_q == LOCKED);
            default:    ;
        endcase
        for (int n = 0; n < NUM_IN; n++)
            if (req.addr == slot_addr(A_IN_BASE, n)) rdata[NUM_CH-1:0] = in_mask_q[n];
        for (int m = 0; m < NUM_OUT; m++)
            if (req.addr == slot_addr(A_OUT_BASE, m)) rdata[NUM_CH-1:0] = out_mask_q[m];
    end

    // R4
    locked_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q == LOCKED && req.we && req.addr != A_KEY)
        |=> ($stable(en_q) && $stable(app_q) && $stable(in_mask_q) && $stable(out_mask_q)));

    // R3
    key_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.addr == A_KEY && req.wdata == UNLOCK_KEY) |=> lock_q == UNLOCKED);

    // R3
    key_relock_chk: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.addr == A_KEY && req.wdata != UNLOCK_KEY) |=> lock_q == LOCKED);

    // R9
    pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_q != '0 && !(req.we && req.addr == A_APP_PULSE)) |=> pulse_q == '0);

endmodule

// File: rtl/ctr_route.sv
module ctr_route
    import ctr_pkg::*;
#(
    parameter int NUM_IN  = DEF_NUM_IN,
    parameter int NUM_OUT = DEF_NUM_OUT,
    parameter int NUM_CH  = DEF_NUM_CH
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            en,
    input  logic [NUM_IN-1:0]               trig_in,
    input  logic [NUM_CH-1:0]               app_ch,
    input  logic [NUM_CH-1:0]               pulse_ch,
    input  logic [NUM_IN-1:0][NUM_CH-1:0]   in_mask,
    input  logic [NUM_OUT-1:0][NUM_CH-1:0]  out_mask,
    input  logic [NUM_OUT-1:0]              ack,
    output logic [NUM_CH-1:0]               chan_in,
    output logic [NUM_CH-1:0]               chan_out,
    output logic [NUM_OUT-1:0]              trig_out
);

    logic [NUM_OUT-1:0] hit;
    logic [NUM_OUT-1:0] out_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [NUM_IN-1:0] drivers;
        for (genvar n = 0; n < NUM_IN; n++) begin : g_src
            assign drivers[n] = trig_in[n] & in_mask[n][c];
        end
        assign chan_in[c] = (|drivers) | app_ch[c] | pulse_ch[c];
    end

    assign chan_out = en ? chan_in : '0;

    for (genvar m = 0; m < NUM_OUT; m++) begin : g_out
        assign hit[m] = |(chan_out & out_mask[m]);
    end

    always_ff @(posedge clk) begin
        if (rst)     out_q <= '0;
        else if (en) out_q <= (out_q & ~ack) | hit;
        else         out_q <= '0;
    end

    assign trig_out = out_q;

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> out_q == '0);

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ack == '0) |=> (out_q & $past(out_q)) == $past(out_q));

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ack != '0) |=> (out_q & $past(ack & ~hit)) == '0);

endmodule

// File: rtl/cross_trig_router.sv
module cross_trig_router
    import ctr_pkg::*;
#(
    parameter int NUM_IN  = DEF_NUM_IN,
    parameter int NUM_OUT = DEF_NUM_OUT,
    parameter int NUM_CH  = DEF_NUM_CH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_IN-1:0]    trig_in,
    output logic [NUM_OUT-1:0]   trig_out
);

    bus_req_t                       req;
    logic                           en;
    logic [NUM_CH-1:0]              app_ch;
    logic [NUM_CH-1:0]              pulse_ch;
    logic [NUM_IN-1:0][NUM_CH-1:0]  in_mask;
    logic [NUM_OUT-1:0][NUM_CH-1:0] out_mask;
    logic [NUM_OUT-1:0]             ack;
    logic [NUM_CH-1:0]              chan_in;
    logic [NUM_CH-1:0]              chan_out;

    assign req = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};

    ctr_regs #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .trig_in  (trig_in),
        .trig_out (trig_out),
        .chan_in  (chan_in),
        .chan_out (chan_out),
        .en       (en),
        .app_ch   (app_ch),
        .pulse_ch (pulse_ch),
        .in_mask  (in_mask),
        .out_mask (out_mask),
        .ack      (ack),
        .rdata    (bus_rdata)
    );

    ctr_route #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_route (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .trig_in  (trig_in),
        .app_ch   (app_ch),
        .pulse_ch (pulse_ch),
        .in_mask  (in_mask),
        .out_mask (out_mask),
        .ack      (ack),
        .chan_in  (chan_in),
        .chan_out (chan_out),
        .trig_out (trig_out)
    );

endmodule

// File: tb/test_cross_trig_router.sv
module test_cross_trig_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  trig_in = '0;
    logic [7:0]  trig_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // scoreboard: kind 0 = read data, kind 1 = trigger output port
    bit          sb_kind[$];
    logic [31:0] sb_exp[$];
    string       sb_tag[$];

    always #5 clk = ~clk;

    cross_trig_router i_cross_trig_router (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .trig_out(trig_out)
    );

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb_kind.size() > 0) begin
                bit          k;
                logic [31:0] e;
                logic [31:0] a;
                string       t;
                k = sb_kind.pop_front();
                e = sb_exp.pop_front();
                t = sb_tag.pop_front();
                a = k ? {24'h0, trig_out} : bus_rdata;
                n_vec++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd_exp(input logic [9:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a;
        sb_kind.push_back(1'b0); sb_exp.push_back(e); sb_tag.push_back(t);
    endtask

    task automatic out_exp(input logic [7:0] e, input string t);
        @(posedge clk); #1;
        sb_kind.push_back(1'b1); sb_exp.push_back({24'h0, e}); sb_tag.push_back(t);
    endtask

    task automatic drive_in(input logic [7:0] v);
        @(posedge clk); #1;
        trig_in = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd_exp(10'h3ED, 32'h1, "R1 lock status");
        rd_exp(10'h000, 32'h0, "R1 control");
        rd_exp(10'h00A, 32'h0, "R1 input mask");
        out_exp(8'h00, "R1 outputs");

        // R4 locked writes refused
        wr(10'h000, 32'h1);
        wr(10'h00A, 32'hF);
        rd_exp(10'h000, 32'h0, "R4 control while locked");
        rd_exp(10'h00A, 32'h0, "R4 mask while locked");

        // R3 wrong key keeps locked, right key unlocks
        wr(10'h3EC, 32'hC5AC_CE54);
        rd_exp(10'h3ED, 32'h1, "R3 wrong key");
        wr(10'h3EC, 32'hC5AC_CE55);
        rd_exp(10'h3ED, 32'h0, "R3 unlocked");

        // R2 mask programming and truncation
        wr(10'h00A, 32'hFFFF_FFF1);
        wr(10'h02D, 32'h1);
        rd_exp(10'h00A, 32'h1, "R2 input mask readback");
        rd_exp(10'h02D, 32'h1, "R2 output mask readback");
        wr(10'h000, 32'h1);
        rd_exp(10'h000, 32'h1, "R5 control enabled");

        // R6 routing input 2 -> ch0 -> output 5, sticky
        drive_in(8'h04);
        rd_exp(10'h04E, 32'h1, "R10 channel input status");
        out_exp(8'h20, "R6 output latched");
        rd_exp(10'h04C, 32'h4, "R10 input status");
        rd_exp(10'h04D, 32'h20, "R10 output status");
        drive_in(8'h00);
        out_exp(8'h20, "R6 output held after input drops");
        rd_exp(10'h04E, 32'h0, "R10 channel idle");

        // R7 acknowledge
        wr(10'h004, 32'h20);
        out_exp(8'h00, "R7 ack clears");
        drive_in(8'h04);
        out_exp(8'h20, "R7 relatch");
        wr(10'h004, 32'h20);
        out_exp(8'h20, "R7 set wins over ack");
        drive_in(8'h00);
        wr(10'h004, 32'h20);
        out_exp(8'h00, "R7 ack after drop");
        drive_in(8'h01);
        out_exp(8'h00, "R2 unmapped input has no effect");
        drive_in(8'h00);

        // R8 application channel
        wr(10'h028, 32'h2);
        wr(10'h005, 32'h2);
        out_exp(8'h01, "R8 app set drives output 0");
        rd_exp(10'h005, 32'h2, "R8 app readback");
        rd_exp(10'h04F, 32'h2, "R10 channel out status");
        wr(10'h006, 32'h2);
        wr(10'h004, 32'h01);
        out_exp(8'h00, "R8 app clear then ack");
        rd_exp(10'h005, 32'h0, "R8 app cleared");

        // R9 pulse
        wr(10'h007, 32'h1);
        out_exp(8'h20, "R9 pulse latches output 5");
        rd_exp(10'h04E, 32'h0, "R9 pulse gone");
        wr(10'h004, 32'h20);
        out_exp(8'h00, "R9 ack after pulse");

        // R11 unmapped and write-only reads
        rd_exp(10'h3FF, 32'h0, "R11 unmapped high");
        rd_exp(10'h100, 32'h0, "R11 unmapped mid");
        rd_exp(10'h3EC, 32'h0, "R11 key reads zero");

        // R5 disable
        drive_in(8'h04);
        out_exp(8'h20, "R5 pre-disable");
        wr(10'h000, 32'h0);
        out_exp(8'h00, "R5 disabled outputs low");
        rd_exp(10'h04F, 32'h0, "R5 channel out gated");
        rd_exp(10'h04E, 32'h1, "R10 channel in ungated");
        drive_in(8'h00);

        // R3 relock, R4 refused again
        wr(10'h3EC, 32'h0);
        rd_exp(10'h3ED, 32'h1, "R3 relocked");
        wr(10'h000, 32'h1);
        rd_exp(10'h000, 32'h0, "R4 control refused after relock");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule